// File: doc/BRIEF.md
# Reloadable System Tick Timer

This block is a periodic down-counter for generating an operating-system time base. Software programs a 24-bit reload value and then starts the counter. The counter steps down once for each selected tick. On the tick that takes the count from one to zero, the block sets a sticky event flag and, if interrupts are allowed, sends a one-cycle interrupt request. On the tick after that, the count is reloaded and the period starts again. The tick comes either from every core clock or from an external slow reference input. The reference input is synchronized into the clock domain and then edge-detected.

Software reaches the block through a single-cycle register port with four word registers: control, reload, current count and calibration. The port has no wait states and no back-pressure. A write or read presented on any cycle completes on the next rising clock edge. Read data is valid combinationally in the same cycle that the read strobe is high. Reading the control register returns the event flag and clears it. Writing any value to the count register zeroes the count and clears the event flag.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and count registers read as 0, and `irq` is low.
- R2: Registers sit at byte offsets 0x0 (control), 0x4 (reload), 0x8 (count) and 0xC (calibration). Control bit 0 is run, bit 1 is interrupt allow, bit 2 is source select, and bit 16 is the event flag. Every other control bit reads 0, and writes to those bits, and to bit 16, have no effect.
- R3: The reload register holds 24 bits in bits 23:0, and bits 31:24 always read 0.
- R4: While running with source select = 1, the count changes on every clock. A nonzero count decrements by 1, and a count of 0 loads the reload value.
- R5: While running with source select = 0, the count steps exactly once for each rising edge of `ref_tick`. The step happens two synchronizer cycles after the edge, and the core clock alone never steps the count.
- R6: While run = 0, the count holds its value.
- R7: The event flag sets on the step from 1 to 0 and reads as bit 16 of control. A control read returns the flag and clears it.
- R8: A write of any data to the count register sets the count to 0 and clears the event flag.
- R9: With interrupt allow = 1, each step from 1 to 0 produces a one-cycle pulse on `irq` in the following cycle. With interrupt allow = 0, `irq` stays low but the flag still sets.
- R10: A reload value of 0 leaves the counter at 0 after the next wrap, with no further flag or interrupt events.
- R11: If a step to 0 and a clearing control read or count write fall on the same edge, the flag ends set.
- R12: The calibration register is read-only. It returns the 10 ms reload value in bits 23:0 (default 120000, 0x01D4C0) and the inexact bit in bit 30 (default 1), so the default read is 0x4001D4C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, completes at the next edge |
| bus_rd | input | 1 | Read strobe, data valid in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| ref_tick | input | 1 | Slow reference tick, asynchronous to clk |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions take for granted that `bus_wr` and `bus_rd` are never high in the same cycle, that addresses are word-aligned within the four registers, and that each `ref_tick` level lasts longer than the synchronizer so that no edge is lost. The directed stimulus drives strobes from one task at a time and holds each `ref_tick` level for three clocks. Flag and interrupt checks time the event edge to fall on a chosen bus cycle, so both the same-edge cases and the ordinary cases occur.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Word index decoded from address bits 3:2
  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IRQ_BIT  = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;
  localparam int CALIB_SKEW_BIT = 30;

  typedef struct packed {
    logic src_core;  // 1: step on every clock
    logic irq_en;    // allow interrupt pulse
    logic run;       // counter enabled
  } ctrl_t;

endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic src_core,
  output logic tick_en
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ref_tick};
      last_q <= sync_q[MSB];
    end
  end

  assign tick_en = src_core | (sync_q[MSB] & ~last_q);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step     = run & tick_en;
  assign zero_evt = step & (count == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (clr)        count <= '0;
    else if (step) begin
      if (count == '0)   count <= reload;
      else               count <= count - ONE;
    end
  end

endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              ADDR_W    = 4,
  parameter int              CNT_W     = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS = 24'd120000,
  parameter logic            CAL_SKEW  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              zero_evt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_clr,
  output logic              flag,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  reg_sel_e sel;
  logic     in_range;
  logic     ctrl_wr, reload_wr, ctrl_rd;
  logic     unused_bus;

  assign sel       = reg_sel_e'(addr[3:2]);
  assign in_range  = ((addr >> 4) == '0);
  assign ctrl_wr   = wr_en & in_range & (sel == REG_CTRL);
  assign reload_wr = wr_en & in_range & (sel == REG_RELOAD);
  assign cur_clr   = wr_en & in_range & (sel == REG_CURRENT);
  assign ctrl_rd   = rd_en & in_range & (sel == REG_CTRL);
  assign unused_bus = ^{wr_data, addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      flag   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl.run      <= wr_data[CTRL_RUN_BIT];
        ctrl.irq_en   <= wr_data[CTRL_IRQ_BIT];
        ctrl.src_core <= wr_data[CTRL_SRC_BIT];
      end
      if (reload_wr) reload <= wr_data[CNT_W-1:0];
      // a hardware event outranks any clearing access
      if (zero_evt)                flag <= 1'b1;
      else if (ctrl_rd || cur_clr) flag <= 1'b0;
      irq <= zero_evt & ctrl.irq_en;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && in_range) begin
      case (sel)
        REG_CTRL: begin
          rd_data[CTRL_RUN_BIT]  = ctrl.run;
          rd_data[CTRL_IRQ_BIT]  = ctrl.irq_en;
          rd_data[CTRL_SRC_BIT]  = ctrl.src_core;
          rd_data[CTRL_FLAG_BIT] = flag;
        end
        REG_RELOAD:  rd_data[CNT_W-1:0] = reload;
        REG_CURRENT: rd_data[CNT_W-1:0] = count;
        REG_CALIB: begin
          rd_data[CNT_W-1:0]     = CAL_TENMS;
          rd_data[CALIB_SKEW_BIT] = CAL_SKEW;
        end
        default: rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               ADDR_W      = 4,
  parameter int               CNT_W       = 24,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CAL_TENMS   = 24'd120000,
  parameter logic             CAL_SKEW    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             tick_en;
  logic             zero_evt;
  logic             cur_clr;
  logic             flag_q;

  tick_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .src_core (ctrl_q.src_core),
    .tick_en  (tick_en)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .tick_en  (tick_en),
    .clr      (cur_clr),
    .reload   (reload_q),
    .count    (count_q),
    .zero_evt (zero_evt)
  );

  tick_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .CAL_TENMS (CAL_TENMS),
    .CAL_SKEW  (CAL_SKEW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .wr_data  (bus_wdata),
    .count    (count_q),
    .zero_evt (zero_evt),
    .ctrl     (ctrl_q),
    .reload   (reload_q),
    .cur_clr  (cur_clr),
    .flag     (flag_q),
    .irq      (irq),
    .rd_data  (bus_rdata)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input ctrl_t             ctrl_q,
  input logic              tick_en,
  input logic [CNT_W-1:0]  count_q,
  input logic              zero_evt,
  input logic              flag_q
);
  logic cnt_wr, ctrl_rd, rld_rd;
  assign cnt_wr  = bus_wr && (bus_addr == ADDR_W'(8));
  assign ctrl_rd = bus_rd && (bus_addr == ADDR_W'(0));
  assign rld_rd  = bus_rd && (bus_addr == ADDR_W'(4));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && tick_en && count_q != '0 && !cnt_wr) |=> (count_q == $past(count_q - CNT_W'(1))));

  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !cnt_wr) |=> (count_q == $past(count_q)));

  assert_read_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !zero_evt) |=> !flag_q);

  assert_write_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == '0));

  assert_irq_allowed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_q.irq_en));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count_q == '0));

  assert_event_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag_q);

  assert_reload_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rld_rd |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

endmodule

bind tick_timer tick_timer_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .tick_en   (tick_en),
  .count_q   (count_q),
  .zero_evt  (zero_evt),
  .flag_q    (flag_q)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(A_CTRL, 32'h0);
    wr(A_CUR, 32'h0);
  endtask

  task automatic t_reset();
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_RLD, v);  chk("R1 reload", v, 32'h0);
    rd(A_CUR, v);  chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map();
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 ctrl fields only", v, 32'h7);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R2 ctrl cleared", v, 32'h0);
    wr(A_RLD, 32'hABCD_EF12);
    rd(A_RLD, v); chk("R3 reload upper zero", v, 32'h00CD_EF12);
    rd(A_CAL, v); chk("R12 calib", v, 32'h4001_D4C0);
    wr(A_CAL, 32'h0);
    rd(A_CAL, v); chk("R12 calib read-only", v, 32'h4001_D4C0);
  endtask

  task automatic t_core_run();
    quiesce();
    wr(A_RLD, 32'd10);
    wr(A_CTRL, 32'h5);
    for (int i = 0; i < 25; i++) begin
      rd(A_CUR, v);
      chk("R4 count sequence", v, (i == 0) ? 32'd0 : 32'(10 - ((i - 1) % 11)));
    end
    quiesce();
  endtask

  task automatic t_flag_read();
    quiesce();
    wr(A_RLD, 32'd3);
    wr(A_CTRL, 32'h5);
    idle(6);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R7 flag set", v, 32'h0001_0000);
    rd(A_CTRL, v); chk("R7 flag cleared by read", v, 32'h0);
    rd(A_CUR, v);  chk("R6 count frozen", v, 32'd1);
    idle(10);
    rd(A_CUR, v);  chk("R6 count still frozen", v, 32'd1);
  endtask

  task automatic t_cur_write();
    quiesce();
    wr(A_RLD, 32'd2);
    wr(A_CTRL, 32'h5);
    idle(3);
    wr(A_CTRL, 32'h0);
    rd(A_CUR, v); chk("R8 count before write", v, 32'd2);
    wr(A_CUR, 32'h1234_5678);
    rd(A_CUR, v); chk("R8 count zeroed", v, 32'd0);
    rd(A_CTRL, v); chk("R8 flag cleared", v, 32'h0);
  endtask

  task automatic t_ref_src();
    quiesce();
    wr(A_RLD, 32'd5);
    wr(A_CTRL, 32'h1);
    idle(5);
    rd(A_CUR, v); chk("R5 no step without ref", v, 32'd0);
    for (int k = 0; k < 4; k++) begin
      ref_tick = 1'b1; idle(3);
      ref_tick = 1'b0; idle(3);
    end
    idle(4);
    rd(A_CUR, v); chk("R5 one step per ref edge", v, 32'd2);
    quiesce();
  endtask

  task automatic t_irq();
    int base;
    quiesce();
    wr(A_RLD, 32'd2);
    base = irq_cnt;
    wr(A_CTRL, 32'h7);
    idle(20);
    wr(A_CTRL, 32'h0);
    idle(3);
    chk("R9 irq pulses", 32'(irq_cnt - base), 32'd7);
    quiesce();
    base = irq_cnt;
    wr(A_CTRL, 32'h5);
    idle(20);
    wr(A_CTRL, 32'h0);
    idle(3);
    chk("R9 no irq when disallowed", 32'(irq_cnt - base), 32'd0);
    rd(A_CTRL, v); chk("R9 flag without irq", v, 32'h0001_0000);
  endtask

  task automatic t_zero_reload();
    int base;
    quiesce();
    wr(A_RLD, 32'd3);
    base = irq_cnt;
    wr(A_CTRL, 32'h7);
    idle(2);
    wr(A_RLD, 32'd0);
    idle(8);
    rd(A_CUR, v);  chk("R10 idle at zero", v, 32'd0);
    rd(A_CTRL, v); chk("R10 last wrap flagged", v, 32'h0001_0007);
    idle(5);
    rd(A_CTRL, v); chk("R10 no further flag", v, 32'h7);
    chk("R10 single irq", 32'(irq_cnt - base), 32'd1);
    quiesce();
  endtask

  task automatic t_set_wins();
    quiesce();
    wr(A_RLD, 32'd2);
    wr(A_CTRL, 32'h5);
    idle(2);
    rd(A_CTRL, v); chk("R11 flag before event", v, 32'h5);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R11 set beats read clear", v, 32'h0001_0000);
    quiesce();
    wr(A_RLD, 32'd2);
    wr(A_CTRL, 32'h5);
    idle(2);
    wr(A_CUR, 32'h0);
    rd(A_CUR, v); chk("R11 count written to zero", v, 32'd0);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R11 set beats write clear", v, 32'h0001_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_map();
    t_core_run();
    t_flag_read();
    t_cur_write();
    t_ref_src();
    t_irq();
    t_zero_reload();
    t_set_wins();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule